// File: doc/BRIEF.md
# GPIO Interrupt and Wake Aggregator

This block gathers interrupt and wake events from a set of GPIO pins into one parent interrupt line. Each pin owns a control word that enables status capture, masks delivery, selects edge or level triggering with a polarity, and picks the sleep states in which an event also records a wake. Software finds the source through a summary vector in which each bit stands for four neighbouring pins, acknowledges each pin by writing its status bits back as ones, and closes the interrupt with an end-of-interrupt write to the control register.

The pin inputs are already filtered: a level per pin plus single-cycle rise and fall pulses. When the global suppression option is on, any write that touches a pin's debounce byte opens a window of a programmed number of clock cycles in which no pin records status and every pin's enable bit reads back as 0, so software can poll for the end of the window.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset every pin control word, the control register, both summary words, the read data and `irq_out` are 0.
- R2: In edge mode (word bit 2 = 0) the polarity field (bits 4:3) selects 0 = rising pulse, 1 = falling pulse, 2 = either pulse, 3 = nothing; interrupt status (bit 16) is set on the clock edge that samples the pulse and stays set until cleared.
- R3: In level mode (bit 2 = 1) polarity 0 sets status on every cycle the pin level is 1 and polarity 1 on every cycle it is 0, overriding a clear in the same cycle; polarities 2 and 3 never set status.
- R4: With interrupt enable (bit 0) at 0, no event sets interrupt status.
- R5: Writing 1 to bit 16 or 17 with byte strobe 2 clears interrupt or wake status; writing 0, or writing without byte strobe 2, leaves it.
- R6: `irq_out` is a register that rises one cycle after some pin has status set with unmask (bit 1) at 1; pending status on masked pins does not raise it.
- R7: Summary bit g (address 192 holds bits 31:0, address 193 bits 63:32) is the OR of interrupt and wake status of pins 4g to 4g+3, masked or not; bits at and above NUM_PINS/4 read 0.
- R8: A write of 1 to control bit 0 (byte strobe 0, address 194) drops `irq_out` for the next cycle; it rises again one cycle later only if unmasked status remains. Control bit 0 reads 0.
- R9: Wake status (bit 17) is set by a pin event when `pwr_state` is 1, 2 or 3 and wake-enable bit 4+`pwr_state` (bits 5, 6, 7) is 1, independent of interrupt enable; in state 0 it is never set.
- R10: With suppression enable (control bit 4) at 1, a write with byte strobe 1 to any pin opens a window of L cycles (L = control bits 27:16, written by byte strobe 2); on the L clock edges after the write no pin sets any status, and reads of pin words return bit 0 as 0 while the stored enable is kept.
- R11: A debounce write made inside an open window does not lengthen it, and with suppression enable at 0 a debounce write opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_strb | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word at bus_addr, one cycle later |
| pin_level | input | NUM_PINS | Filtered pin levels |
| pin_rise | input | NUM_PINS | Single-cycle rising-change pulses |
| pin_fall | input | NUM_PINS | Single-cycle falling-change pulses |
| pwr_state | input | 2 | Current sleep state: 0 run, 1 light idle, 2 suspend, 3 off |
| irq_out | output | 1 | Parent interrupt line |

## Verification
The bench builds the block with 16 pins, which gives four summary groups and leaves the whole upper summary word as read-as-zero bits. That small size lets it sweep every pin through every trigger and polarity code, every pin through the masked-then-unmasked path into the summary, and every sleep state against every wake-enable bit. Short suppression lengths of 5, 6 and 20 cycles put the window's first and last suppressed edges and a second write in mid-window at cycle-exact positions.

// File: rtl/gia_pkg.sv
package gia_pkg;
  localparam int WORD_W   = 32;
  localparam int SUM_W    = 2 * WORD_W;
  localparam int DB_W     = 8;
  localparam int CFG_W    = 16;
  localparam int B_IEN    = 0;
  localparam int B_ISTS   = 16;
  localparam int B_WSTS   = 17;
  localparam int B_EOI    = 0;
  localparam int B_SUPEN  = 4;
  localparam int B_LEN    = 16;

  typedef enum logic [1:0] {
    POL_HIGH = 2'd0,
    POL_LOW  = 2'd1,
    POL_ANY  = 2'd2,
    POL_OFF  = 2'd3
  } pol_e;

  typedef enum logic [1:0] {
    PWR_RUN     = 2'd0,
    PWR_IDLE    = 2'd1,
    PWR_SUSPEND = 2'd2,
    PWR_OFF     = 2'd3
  } pwr_e;

  // Packed MSB first: db[15:8] wake[7:5] pol[4:3] lvl[2] unmask[1] ien[0]
  typedef struct packed {
    logic [DB_W-1:0] db;
    logic [2:0]      wake;
    pol_e            pol;
    logic            lvl;
    logic            unmask;
    logic            ien;
  } pin_cfg_t;
endpackage

// File: rtl/gia_pin_cell.sv
module gia_pin_cell
  import gia_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_sel,
  input  logic [2:0]  wr_strb,
  input  logic [17:0] wr_data,
  input  logic        lvl_in,
  input  logic        rise_in,
  input  logic        fall_in,
  input  logic        suppress,
  input  pwr_e        pwr,
  output pin_cfg_t    cfg,
  output logic        irq_sts,
  output logic        wake_sts,
  output logic        db_write
);
  logic hit;
  logic wake_ok;
  logic set_irq;
  logic set_wake;
  logic clr_irq;
  logic clr_wake;

  always_comb begin
    hit = 1'b0;
    if (cfg.lvl) begin
      unique case (cfg.pol)
        POL_HIGH: hit = lvl_in;
        POL_LOW:  hit = !lvl_in;
        default:  hit = 1'b0;
      endcase
    end else begin
      unique case (cfg.pol)
        POL_HIGH: hit = rise_in;
        POL_LOW:  hit = fall_in;
        POL_ANY:  hit = rise_in | fall_in;
        default:  hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (pwr)
      PWR_IDLE:    wake_ok = cfg.wake[0];
      PWR_SUSPEND: wake_ok = cfg.wake[1];
      PWR_OFF:     wake_ok = cfg.wake[2];
      default:     wake_ok = 1'b0;
    endcase
  end

  assign set_irq  = hit && cfg.ien && !suppress;
  assign set_wake = hit && wake_ok && !suppress;
  assign clr_irq  = wr_sel && wr_strb[2] && wr_data[B_ISTS];
  assign clr_wake = wr_sel && wr_strb[2] && wr_data[B_WSTS];
  assign db_write = wr_sel && wr_strb[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      irq_sts  <= 1'b0;
      wake_sts <= 1'b0;
    end else begin
      if (wr_sel && wr_strb[0]) cfg[7:0] <= wr_data[7:0];
      if (db_write)             cfg.db   <= wr_data[15:8];
      if (set_irq)       irq_sts <= 1'b1;
      else if (clr_irq)  irq_sts <= 1'b0;
      if (set_wake)      wake_sts <= 1'b1;
      else if (clr_wake) wake_sts <= 1'b0;
    end
  end

  assert_quiet_in_window_R10: assert property (@(posedge clk) disable iff (rst)
    (suppress && !irq_sts && !wake_sts) |=> (!irq_sts && !wake_sts));

  assert_disabled_no_status_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg.ien && !irq_sts) |=> !irq_sts);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wr_strb[2] && wr_data[B_ISTS] && !cfg.lvl && !rise_in && !fall_in)
      |=> !irq_sts);

  assert_status_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_sts && !(wr_sel && wr_strb[2] && wr_data[B_ISTS])) |=> irq_sts);
endmodule

// File: rtl/gia_sts_window.sv
module gia_sts_window #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (active) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (en && trig) begin
      cnt_q <= len;
    end
  end

  assert_no_extend_R11: assert property (@(posedge clk) disable iff (rst)
    (active && trig) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_off_stays_closed_R11: assert property (@(posedge clk) disable iff (rst)
    (!en && !active) |=> !active);

  assert_window_opens_R10: assert property (@(posedge clk) disable iff (rst)
    (!active && en && trig && (len != '0)) |=> active);
endmodule

// File: rtl/gia_group_or.sv
module gia_group_or #(
  parameter int NUM_PINS = 16,
  parameter int SUM_W    = 64
) (
  input  logic [NUM_PINS-1:0] pend,
  output logic [SUM_W-1:0]    sum
);
  localparam int GROUPS = NUM_PINS / 4;

  for (genvar g = 0; g < SUM_W; g++) begin : g_bit
    if (g < GROUPS) begin : g_live
      assign sum[g] = |pend[4*g +: 4];
    end else begin : g_zero
      assign sum[g] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gia_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int ADDR_W   = 8,
  parameter int LEN_W    = 12,
  parameter logic [ADDR_W-1:0] SUM_LO_ADDR = 8'd192,
  parameter logic [ADDR_W-1:0] SUM_HI_ADDR = 8'd193,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'd194
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [3:0]          bus_strb,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] pin_rise,
  input  logic [NUM_PINS-1:0] pin_fall,
  input  logic [1:0]          pwr_state,
  output logic                irq_out
);
  localparam logic [ADDR_W-1:0] PIN_LIMIT = ADDR_W'(NUM_PINS);

  pin_cfg_t            cfg_a [NUM_PINS];
  logic [NUM_PINS-1:0] ists;
  logic [NUM_PINS-1:0] wsts;
  logic [NUM_PINS-1:0] unmask_v;
  logic [NUM_PINS-1:0] dbw_v;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] deliver;
  logic [SUM_W-1:0]    summary;
  logic                win_active;
  logic                sup_en_q;
  logic [LEN_W-1:0]    len_q;
  logic                ctrl_wr;
  logic                eoi_wr;
  logic [31:0]         rd_next;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gia_pin_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .wr_sel   (bus_wr && (bus_addr == ADDR_W'(i))),
      .wr_strb  (bus_strb[2:0]),
      .wr_data  (bus_wdata[17:0]),
      .lvl_in   (pin_level[i]),
      .rise_in  (pin_rise[i]),
      .fall_in  (pin_fall[i]),
      .suppress (win_active),
      .pwr      (pwr_e'(pwr_state)),
      .cfg      (cfg_a[i]),
      .irq_sts  (ists[i]),
      .wake_sts (wsts[i]),
      .db_write (dbw_v[i])
    );
    assign unmask_v[i] = cfg_a[i].unmask;
  end

  assign pend    = ists | wsts;
  assign deliver = pend & unmask_v;

  gia_group_or #(
    .NUM_PINS (NUM_PINS),
    .SUM_W    (SUM_W)
  ) u_sum (
    .pend (pend),
    .sum  (summary)
  );

  gia_sts_window #(
    .LEN_W (LEN_W)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .en     (sup_en_q),
    .trig   (|dbw_v),
    .len    (len_q),
    .active (win_active)
  );

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  assign eoi_wr  = ctrl_wr && bus_strb[0] && bus_wdata[B_EOI];

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_en_q <= 1'b0;
      len_q    <= '0;
    end else if (ctrl_wr) begin
      if (bus_strb[0]) sup_en_q <= bus_wdata[B_SUPEN];
      if (bus_strb[2]) len_q    <= bus_wdata[B_LEN +: LEN_W];
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr < PIN_LIMIT) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (bus_addr == ADDR_W'(i)) begin
          rd_next[CFG_W-1:0] = cfg_a[i];
          rd_next[B_IEN]     = cfg_a[i].ien && !win_active;
          rd_next[B_ISTS]    = ists[i];
          rd_next[B_WSTS]    = wsts[i];
        end
      end
    end else if (bus_addr == SUM_LO_ADDR) begin
      rd_next = summary[WORD_W-1:0];
    end else if (bus_addr == SUM_HI_ADDR) begin
      rd_next = summary[SUM_W-1:WORD_W];
    end else if (bus_addr == CTRL_ADDR) begin
      rd_next[B_SUPEN]           = sup_en_q;
      rd_next[B_LEN +: LEN_W]    = len_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_out   <= (|deliver) && !eoi_wr;
    end
  end

  assert_eoi_drops_line_R8: assert property (@(posedge clk) disable iff (rst)
    eoi_wr |=> !irq_out);

  assert_line_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|deliver));

  assert_summary_covers_R7: assert property (@(posedge clk) disable iff (rst)
    (|deliver) |-> (|summary));

  assert_enable_hidden_R10: assert property (@(posedge clk) disable iff (rst)
    (win_active && (bus_addr < PIN_LIMIT)) |=> !bus_rdata[B_IEN]);
endmodule

// File: tb/gpio_irq_agg_bench.sv
`timescale 1ns/1ps
module gpio_irq_agg_bench;
  localparam int NP = 16;
  localparam logic [7:0] A_SLO  = 8'd192;
  localparam logic [7:0] A_SHI  = 8'd193;
  localparam logic [7:0] A_CTRL = 8'd194;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    strb = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] level = '0;
  logic [NP-1:0] rise = '0;
  logic [NP-1:0] fall = '0;
  logic [1:0]    pwr = '0;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_agg #(.NUM_PINS(NP), .ADDR_W(8), .LEN_W(12)) u_gpio_irq_agg (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_en), .bus_strb(strb),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_level(level), .pin_rise(rise),
    .pin_fall(fall), .pwr_state(pwr), .irq_out(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
    addr = a; strb = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; strb = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(input int p, input bit up);
    if (up) rise[p] = 1'b1; else fall[p] = 1'b1;
    @(negedge clk);
    rise = '0; fall = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic ex;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq_out", 32'(irq), 0);
    for (int p = 0; p < NP; p++) begin
      rd(8'(p), d); chk("R1 pin word", d, 0);
    end
    rd(A_CTRL, d); chk("R1 control", d, 0);
    rd(A_SLO, d);  chk("R1 summary lo", d, 0);
    rd(A_SHI, d);  chk("R1 summary hi", d, 0);

    // R2 edge mode sweep: every pin, polarity, pulse kind
    for (int p = 0; p < NP; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int k = 0; k < 2; k++) begin
          wr(8'(p), 4'b0001, 32'h3 | 32'(a << 3));
          pulse(p, k == 0);
          rd(8'(p), d);
          ex = (a == 0 && k == 0) || (a == 1 && k == 1) || (a == 2);
          chk("R2 edge status", 32'(d[16]), 32'(ex));
          chk("R6 line follows status", 32'(irq), 32'(ex));
          repeat (3) @(negedge clk);
          rd(8'(p), d);
          chk("R2 status sticky", 32'(d[16]), 32'(ex));
          wr(8'(p), 4'b0101, 32'h0001_0000);
        end
      end
    end

    // R3 level mode sweep
    for (int p = 0; p < NP; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int v = 0; v < 2; v++) begin
          level[p] = v[0];
          wr(8'(p), 4'b0001, 32'h7 | 32'(a << 3));
          @(negedge clk);
          wr(8'(p), 4'b0100, 32'h0001_0000);
          rd(8'(p), d);
          ex = (a == 0 && v == 1) || (a == 1 && v == 0);
          chk("R3 level re-set after clear", 32'(d[16]), 32'(ex));
          wr(8'(p), 4'b0001, 32'h0);
          wr(8'(p), 4'b0100, 32'h0001_0000);
          level[p] = 1'b0;
        end
      end
    end

    // R4 enable off
    wr(8'd4, 4'b0001, 32'h2 | 32'(2 << 3));
    pulse(4, 1'b1);
    rd(8'd4, d);
    chk("R4 no status when disabled", 32'(d[16]), 0);
    chk("R4 line quiet", 32'(irq), 0);
    wr(8'd4, 4'b0001, 32'h0);

    // R5 acknowledge rules
    wr(8'd6, 4'b0001, 32'h1);
    pulse(6, 1'b1);
    wr(8'd6, 4'b0001, 32'h0001_0001);
    rd(8'd6, d); chk("R5 no clear without strobe 2", 32'(d[16]), 1);
    wr(8'd6, 4'b0100, 32'h0);
    rd(8'd6, d); chk("R5 zero write keeps", 32'(d[16]), 1);
    wr(8'd6, 4'b0100, 32'h0001_0000);
    rd(8'd6, d); chk("R5 one write clears", 32'(d[16]), 0);
    wr(8'd6, 4'b0001, 32'h0);

    // R6 / R7 masked pending into summary, then unmask
    for (int p = 0; p < NP; p++) begin
      wr(8'(p), 4'b0001, 32'h1);
      pulse(p, 1'b1);
      rd(A_SLO, d);
      chk("R7 group bit", d, 32'(1) << (p / 4));
      chk("R6 masked not delivered", 32'(irq), 0);
      wr(8'(p), 4'b0001, 32'h3);
      rd(8'(p), d);
      chk("R6 unmasked delivered", 32'(irq), 1);
      wr(8'(p), 4'b0101, 32'h0001_0000);
    end
    wr(8'd1, 4'b0001, 32'h1);
    wr(8'd13, 4'b0001, 32'h1);
    rise[1] = 1'b1; rise[13] = 1'b1;
    @(negedge clk);
    rise = '0;
    rd(A_SLO, d); chk("R7 two groups", d, 32'h9);
    rd(A_SHI, d); chk("R7 upper word zero", d, 0);
    wr(8'd1, 4'b0101, 32'h0001_0000);
    wr(8'd13, 4'b0101, 32'h0001_0000);
    rd(A_SLO, d); chk("R7 cleared", d, 0);

    // R8 end of interrupt
    wr(8'd5, 4'b0001, 32'h3);
    pulse(5, 1'b1);
    rd(8'd5, d);
    chk("R8 line up before eoi", 32'(irq), 1);
    wr(A_CTRL, 4'b0001, 32'h1);
    chk("R8 line drops after eoi", 32'(irq), 0);
    @(negedge clk);
    chk("R8 line returns with pending", 32'(irq), 1);
    rd(A_CTRL, d); chk("R8 eoi reads zero", 32'(d[0]), 0);
    wr(8'd5, 4'b0101, 32'h0001_0000);
    @(negedge clk);
    wr(A_CTRL, 4'b0001, 32'h1);
    @(negedge clk);
    chk("R8 no return when idle", 32'(irq), 0);

    // R9 wake states
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 3; w++) begin
        pwr = 2'(s);
        wr(8'd2, 4'b0001, 32'(1) << (5 + w));
        pulse(2, 1'b1);
        rd(8'd2, d);
        ex = (s != 0) && (w == s - 1);
        chk("R9 wake status", 32'(d[17]), 32'(ex));
        chk("R9 no irq status", 32'(d[16]), 0);
        wr(8'd2, 4'b0101, 32'h0002_0000);
        rd(8'd2, d);
        chk("R5 wake cleared", 32'(d[17]), 0);
      end
    end
    pwr = '0;

    // R11 suppression disabled: debounce write opens nothing
    wr(A_CTRL, 4'b0100, 32'(5) << 16);
    wr(8'd0, 4'b0001, 32'h3);
    wr(8'd0, 4'b0010, 32'h0000_5500);
    pulse(0, 1'b1);
    rd(8'd0, d); chk("R11 no window when off", 32'(d[16]), 1);
    wr(8'd0, 4'b0100, 32'h0001_0000);

    // R10 window of 5 cycles blocks every pin
    wr(A_CTRL, 4'b0001, 32'h10);
    rd(A_CTRL, d); chk("R10 control readback", d, 32'h0005_0010);
    wr(8'd9, 4'b0001, 32'h1);
    wr(8'd0, 4'b0010, 32'h0000_1200);
    rise[0] = 1'b1; rise[9] = 1'b1;
    repeat (5) @(negedge clk);
    rise = '0;
    rd(8'd0, d); chk("R10 pin 0 suppressed", 32'(d[16]), 0);
    rd(8'd9, d); chk("R10 pin 9 suppressed", 32'(d[16]), 0);
    pulse(0, 1'b1);
    rd(8'd0, d); chk("R10 status after window", 32'(d[16]), 1);
    wr(8'd0, 4'b0100, 32'h0001_0000);

    // R10 ack write is not a debounce write
    pulse(0, 1'b1);
    rd(8'd0, d); chk("R10 ack opens no window", 32'(d[16]), 1);
    wr(8'd0, 4'b0100, 32'h0001_0000);

    // R10 enable reads as zero during window
    wr(A_CTRL, 4'b0100, 32'(20) << 16);
    wr(8'd7, 4'b0010, 32'h0000_3400);
    rd(8'd0, d);
    chk("R10 enable hidden", 32'(d[0]), 0);
    chk("R10 unmask still visible", 32'(d[1]), 1);
    repeat (25) @(negedge clk);
    rd(8'd0, d); chk("R10 enable back", 32'(d[0]), 1);

    // R11 second write inside window does not extend it
    wr(A_CTRL, 4'b0100, 32'(6) << 16);
    wr(8'd3, 4'b0010, 32'h0000_0100);
    repeat (2) @(negedge clk);
    wr(8'd3, 4'b0010, 32'h0000_0200);
    repeat (3) @(negedge clk);
    pulse(0, 1'b1);
    rd(8'd0, d); chk("R11 window not extended", 32'(d[16]), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule